// File: doc/BRIEF.md
# Vectored Interrupt Channel Controller

This block gathers up to 128 raw interrupt request lines and presents them as prioritised channels on two interrupt outputs: a fast output and a normal output. Each channel picks the request line it watches through an 8-bit request-number field. It is enabled or disabled through write-one-to-set and write-one-to-clear mask registers, and it is steered to either output through a per-channel route bit.

For each output the block keeps an index register. The register holds the number of the lowest-numbered pending, enabled channel routed to that output, plus one, and it reads zero when no such channel is pending. The output pins are registered and stay high while their index is nonzero. All configuration goes through a simple 32-bit register bus that uses word addresses. Channels 0 and 1 are reserved: they are always enabled and always steered to the fast output.

Top module: `chanctl_vic`

## Requirements
- R1: After reset, channel n selects request line n, channels 2 and above are disabled and routed to the normal output, and both index registers and both outputs are zero.
- R2: Writing the mask-set register of bank b (word address 4+b) enables channel 32b+k for every data bit k that is 1. Zero bits leave their channel unchanged. A read returns the current mask word of that bank.
- R3: Writing the mask-clear register of bank b (word address 8+b) disables channel 32b+k for every data bit k that is 1. Zero bits leave their channel unchanged. A read returns the current mask word of that bank.
- R4: The route register of bank b (word address b) holds one bit per channel 32b+k at bit k. A 1 routes that channel to the fast output and a 0 routes it to the normal output. A write replaces the word and a read returns it.
- R5: Control word i (word address 32+i) holds the request numbers of channels 4i, 4i+1, 4i+2 and 4i+3, in bits 31:24, 23:16, 15:8 and 7:0 respectively. A write sets all four fields, and a read returns them.
- R6: A channel whose request number is not below the number of request lines never becomes pending.
- R7: A channel is pending when its selected request line is high and the channel is enabled. The fast index register (word address 12) and the normal index register (word address 13) each read the pending channel number plus one, and they read 0 when none is pending.
- R8: When several channels on one output are pending, the lowest channel number is reported.
- R9: Channels 0 and 1 are always enabled and routed to the fast output. Writes to bits 1:0 of the clear or route register of bank 0 have no effect.
- R10: Each output pin is high exactly when its index register is nonzero. Both update on the first clock edge after the request or configuration change.
- R11: Reads from word addresses not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | 128 | Raw interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| fiq_o | output | 1 | Fast interrupt output |
| irq_o | output | 1 | Normal interrupt output |

## Verification
The assertions check several properties on every cycle. The two reserved channels stay enabled and fast-routed, and set and clear writes to bank 0 take effect on the next cycle. Each output pin agrees with its index register, the index never exceeds the channel count, and a request on line 0 through channel 0 always yields fast index 1. Only the bench scenarios can show the rest: the channel-by-channel routing of all 128 channels, lowest-number priority across bank boundaries, remapping a channel to another request line without disturbing neighbouring fields, and the rejection of out-of-range request numbers.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int DATA_W   = 32;
    localparam int SEL_W    = 8;
    localparam int BANK_W   = 32;
    localparam int FIELDS   = DATA_W / SEL_W;
    localparam int ROUTE_BASE = 0;
    localparam int SET_BASE   = 4;
    localparam int CLR_BASE   = 8;
    localparam int FIQ_IDX_AD = 12;
    localparam int IRQ_IDX_AD = 13;
    localparam int CTRL_BASE  = 32;
    localparam int RSV_CHANS  = 2;
endpackage

// File: rtl/vic_req_select.sv
module vic_req_select #(
    parameter int NUM_CHAN = 128,
    parameter int NUM_REQ  = 128
) (
    input  logic [NUM_REQ-1:0]                      req_in,
    input  logic [NUM_CHAN-1:0][vic_pkg::SEL_W-1:0] sel,
    output logic [NUM_CHAN-1:0]                     chan_req
);
    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam logic [vic_pkg::SEL_W:0] LIMIT = (vic_pkg::SEL_W+1)'(NUM_REQ);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic [IDX_W-1:0] line;
        logic             in_range;
        assign line     = IDX_W'(sel[c]);
        assign in_range = {1'b0, sel[c]} < LIMIT;
        assign chan_req[c] = in_range & req_in[line];
    end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int N     = 128,
    parameter int IDX_W = 8
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx
);
    // lowest set bit wins; result is position plus one, zero when empty
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i + 1);
        end
    end
endmodule

// File: rtl/chanctl_vic.sv
module chanctl_vic #(
    parameter int NUM_CHAN = 128,
    parameter int NUM_REQ  = 128,
    parameter int ADDR_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               fiq_o,
    output logic               irq_o
);
    import vic_pkg::*;

    localparam int BANKS      = NUM_CHAN / BANK_W;
    localparam int CTRL_WORDS = NUM_CHAN / FIELDS;
    localparam int IDX_W      = $clog2(NUM_CHAN + 1);

    typedef struct packed {
        logic [NUM_CHAN-1:0]            mask;
        logic [NUM_CHAN-1:0]            route;
        logic [NUM_CHAN-1:0][SEL_W-1:0] sel;
        logic [IDX_W-1:0]               fiq_idx;
        logic [IDX_W-1:0]               irq_idx;
        logic                           fiq_out;
        logic                           irq_out;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int n = 0; n < NUM_CHAN; n++) s.sel[n] = SEL_W'(n);
        s.mask[RSV_CHANS-1:0]  = '1;
        s.route[RSV_CHANS-1:0] = '1;
        return s;
    endfunction

    localparam state_t RESET_ST = reset_state();

    state_t st_d, st_q;

    logic [NUM_CHAN-1:0] chan_req;
    logic [NUM_CHAN-1:0] pend_fast;
    logic [NUM_CHAN-1:0] pend_norm;
    logic [IDX_W-1:0]    fast_idx;
    logic [IDX_W-1:0]    norm_idx;

    vic_req_select #(.NUM_CHAN(NUM_CHAN), .NUM_REQ(NUM_REQ)) u_sel (
        .req_in   (req_in),
        .sel      (st_q.sel),
        .chan_req (chan_req)
    );

    assign pend_fast = chan_req & st_q.mask &  st_q.route;
    assign pend_norm = chan_req & st_q.mask & ~st_q.route;

    vic_prio_enc #(.N(NUM_CHAN), .IDX_W(IDX_W)) u_enc_fast (
        .vec (pend_fast),
        .idx (fast_idx)
    );

    vic_prio_enc #(.N(NUM_CHAN), .IDX_W(IDX_W)) u_enc_norm (
        .vec (pend_norm),
        .idx (norm_idx)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            for (int b = 0; b < BANKS; b++) begin
                if (bus_addr == ADDR_W'(ROUTE_BASE + b))
                    st_d.route[b*BANK_W +: BANK_W] = bus_wdata;
                if (bus_addr == ADDR_W'(SET_BASE + b))
                    st_d.mask[b*BANK_W +: BANK_W] = st_q.mask[b*BANK_W +: BANK_W] | bus_wdata;
                if (bus_addr == ADDR_W'(CLR_BASE + b))
                    st_d.mask[b*BANK_W +: BANK_W] = st_q.mask[b*BANK_W +: BANK_W] & ~bus_wdata;
            end
            for (int i = 0; i < CTRL_WORDS; i++) begin
                if (bus_addr == ADDR_W'(CTRL_BASE + i)) begin
                    for (int k = 0; k < FIELDS; k++)
                        st_d.sel[i*FIELDS + k] = bus_wdata[DATA_W-1-k*SEL_W -: SEL_W];
                end
            end
        end
        st_d.mask[RSV_CHANS-1:0]  = '1;
        st_d.route[RSV_CHANS-1:0] = '1;
        st_d.fiq_idx = fast_idx;
        st_d.irq_idx = norm_idx;
        st_d.fiq_out = (fast_idx != '0);
        st_d.irq_out = (norm_idx != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bus_addr == ADDR_W'(ROUTE_BASE + b))
                bus_rdata = st_q.route[b*BANK_W +: BANK_W];
            if (bus_addr == ADDR_W'(SET_BASE + b) || bus_addr == ADDR_W'(CLR_BASE + b))
                bus_rdata = st_q.mask[b*BANK_W +: BANK_W];
        end
        if (bus_addr == ADDR_W'(FIQ_IDX_AD)) bus_rdata = 32'(st_q.fiq_idx);
        if (bus_addr == ADDR_W'(IRQ_IDX_AD)) bus_rdata = 32'(st_q.irq_idx);
        for (int i = 0; i < CTRL_WORDS; i++) begin
            if (bus_addr == ADDR_W'(CTRL_BASE + i)) begin
                for (int k = 0; k < FIELDS; k++)
                    bus_rdata[DATA_W-1-k*SEL_W -: SEL_W] = st_q.sel[i*FIELDS + k];
            end
        end
    end

    assign fiq_o = st_q.fiq_out;
    assign irq_o = st_q.irq_out;

    // observation points for the bound checker
    logic [31:0]      mask_bank0;
    logic [1:0]       route_rsv;
    logic [IDX_W-1:0] fiq_idx_w;
    logic [IDX_W-1:0] irq_idx_w;
    logic [SEL_W-1:0] sel_ch0;
    assign mask_bank0 = st_q.mask[31:0];
    assign route_rsv  = st_q.route[1:0];
    assign fiq_idx_w  = st_q.fiq_idx;
    assign irq_idx_w  = st_q.irq_idx;
    assign sel_ch0    = st_q.sel[0];
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
    parameter int NUM_CHAN = 128,
    parameter int ADDR_W   = 6,
    parameter int IDX_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              req0,
    input logic [31:0]       mask_bank0,
    input logic [1:0]        route_rsv,
    input logic [IDX_W-1:0]  fiq_idx,
    input logic [IDX_W-1:0]  irq_idx,
    input logic [7:0]        sel_ch0,
    input logic              fiq_o,
    input logic              irq_o
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_CHAN);

    p_reserved_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_bank0[1:0] == 2'b11 && route_rsv == 2'b11);

    p_set_applies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(4) |=> (mask_bank0 & $past(bus_wdata)) == $past(bus_wdata));

    p_clear_applies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(8) |=> (mask_bank0[31:2] & $past(bus_wdata[31:2])) == 30'd0);

    p_fiq_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == (fiq_idx != '0));

    p_irq_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (irq_idx != '0));

    p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_idx <= MAX_IDX && irq_idx <= MAX_IDX);

    p_ch0_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req0 && sel_ch0 == 8'd0 |=> fiq_idx == IDX_W'(1));
endmodule

bind chanctl_vic vic_chk #(
    .NUM_CHAN (NUM_CHAN),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
) u_vic_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .req0       (req_in[0]),
    .mask_bank0 (mask_bank0),
    .route_rsv  (route_rsv),
    .fiq_idx    (fiq_idx_w),
    .irq_idx    (irq_idx_w),
    .sel_ch0    (sel_ch0),
    .fiq_o      (fiq_o),
    .irq_o      (irq_o)
);

// File: tb/tb_chanctl_vic.sv
`timescale 1ns/1ps
module tb_chanctl_vic;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] req_in = '0;
    logic         bus_wr = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         fiq_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    chanctl_vic dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fiq_o(fiq_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 6'(a);
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_idx(input string tag, input int efiq, input int eirq);
        logic [31:0] v;
        rd(12, v); check({tag, " fast index"}, v, 32'(efiq));
        rd(13, v); check({tag, " normal index"}, v, 32'(eirq));
        check({tag, " fast pin"}, {31'd0, fiq_o}, {31'd0, efiq != 0});
        check({tag, " normal pin"}, {31'd0, irq_o}, {31'd0, eirq != 0});
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_idx("R1 reset", 0, 0);
        for (int b = 0; b < 4; b++) begin
            rd(4 + b, v); check("R1 mask", v, (b == 0) ? 32'h3 : 32'h0);
            rd(b, v);     check("R1 route", v, (b == 0) ? 32'h3 : 32'h0);
        end
        for (int i = 0; i < 32; i++) begin
            rd(32 + i, v);
            check("R1 R5 control word", v, {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)});
        end

        // R9: reserved channels always on and fast
        wr(8, 32'hFFFF_FFFF);
        wr(0, 32'h0);
        rd(4, v); check("R9 mask after clear", v, 32'h3);
        rd(0, v); check("R9 route after write", v, 32'h3);
        req_in[1] = 1'b1; settle();
        check_idx("R9 channel 1", 2, 0);
        req_in[0] = 1'b1; settle();
        check_idx("R8 R9 channel 0 over 1", 1, 0);
        req_in = '0; settle();
        check_idx("R10 released", 0, 0);

        // R4 R7 R10: sweep each channel through both outputs
        for (int n = 2; n < 128; n++) begin
            req_in = '0; req_in[n] = 1'b1;
            settle();
            check_idx("R7 masked", 0, 0);
            wr(4 + n/32, 32'd1 << (n % 32));
            settle();
            check_idx("R7 R10 normal", 0, n + 1);
            wr(n/32, 32'd1 << (n % 32));
            settle();
            check_idx("R4 fast", n + 1, 0);
            wr(8 + n/32, 32'd1 << (n % 32));
            wr(n/32, 32'h0);
            settle();
            check_idx("R3 disabled", 0, 0);
        end
        req_in = '0;

        // R2 R3: zero bits leave state alone, both addresses read the mask
        wr(5, 32'h20);
        wr(5, 32'h200);
        rd(5, v); check("R2 set accumulate", v, 32'h220);
        rd(9, v); check("R3 clear reads mask", v, 32'h220);
        wr(9, 32'h20);
        rd(5, v); check("R3 clear one bit", v, 32'h200);
        wr(9, 32'h0);
        rd(5, v); check("R3 zero write", v, 32'h200);
        wr(9, 32'hFFFF_FFFF);

        // R8: priority among several pending channels
        for (int b = 0; b < 4; b++) wr(4 + b, 32'hFFFF_FFFF);
        for (int p = 0; p < 5; p++) begin
            int a, c;
            case (p)
                0: begin a = 2;  c = 3;   end
                1: begin a = 5;  c = 100; end
                2: begin a = 31; c = 32;  end
                3: begin a = 64; c = 127; end
                default: begin a = 40; c = 96; end
            endcase
            req_in = '0; req_in[a] = 1'b1; req_in[c] = 1'b1;
            settle();
            check_idx("R8 pair", 0, a + 1);
            req_in[0] = 1'b1;
            settle();
            check_idx("R8 R9 pair with reserved", 1, a + 1);
        end
        wr(3, 32'hFFFF_FFFF);
        req_in = '0; req_in[3] = 1'b1; req_in[100] = 1'b1; req_in[120] = 1'b1;
        settle();
        check_idx("R4 R8 split outputs", 101, 4);
        wr(3, 32'h0);
        for (int b = 0; b < 4; b++) wr(8 + b, 32'hFFFF_FFFF);
        req_in = '0;

        // R5 R6: remap channel 10 to request 77
        wr(34, {8'd8, 8'd9, 8'd77, 8'd11});
        rd(34, v); check("R5 written word", v, {8'd8, 8'd9, 8'd77, 8'd11});
        rd(33, v); check("R5 neighbour word", v, {8'd4, 8'd5, 8'd6, 8'd7});
        rd(35, v); check("R5 neighbour word", v, {8'd12, 8'd13, 8'd14, 8'd15});
        wr(4, 32'd1 << 10);
        req_in[77] = 1'b1; settle();
        check_idx("R5 remapped request", 0, 11);
        req_in = '0; req_in[10] = 1'b1; settle();
        check_idx("R5 old line ignored", 0, 0);
        wr(34, {8'd8, 8'd9, 8'd200, 8'd11});
        req_in = '1; settle();
        check_idx("R6 out of range select", 1, 0);
        req_in = '0;

        // R11: unused addresses
        rd(16, v); check("R11 unused read", v, 32'h0);
        rd(31, v); check("R11 unused read", v, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule